// File: doc/BRIEF.md
# Banked Address Map Decoder

This block sits between the core of a small 8-bit-data, 16-bit-address controller and its memories. Each cycle it takes the logical address of the core and produces two things: a wider physical address and a one-hot select for the region that should answer the access. Both outputs are combinational from the address, the page register and the init register.

Physical translation uses a bank window. Logical addresses that fall inside the window are rebased onto the current page. The page is scaled by a configurable shift and then offset by a virtual base. Addresses outside the window are passed through unchanged. The window bounds, the shift and the virtual base are static strap values. They are captured into registers only while reset is held.

Region decode works on the logical address. The init register moves the peripheral register block and the internal RAM block in 4 KB steps. A fixed EEPROM block sits at a parameterised address. When blocks overlap, a fixed priority chooses a single winner. Any address that no block claims goes to external RAM.

Top module: `banked_addr_map`

## Requirements
- R1: For a logical address A with win_lo <= A < win_hi, phys_addr equals (A - win_lo) + (page_reg << win_shift) + virt_base, truncated to 24 bits.
- R2: For any address below win_lo, or at or above win_hi, phys_addr equals A zero-extended to 24 bits. An address equal to win_hi is outside the window.
- R3: win_lo, win_hi, win_shift and virt_base are captured on clock edges where rst is high. Changing them while rst is low has no effect on phys_addr.
- R4: The peripheral register block starts at init_reg[3:0] times 4096. It spans 64 bytes when WIDE_IO is 0. An address inside it drives region_sel = 4'b0001.
- R5: The internal RAM block starts at init_reg[7:4] times 4096 and spans 256 bytes. An address inside it, and in no higher-priority block, drives region_sel = 4'b0100.
- R6: The EEPROM block spans 512 bytes from EE_BASE (default 16'hF000). An address inside it, and outside the peripheral block, drives region_sel = 4'b0010.
- R7: Where blocks overlap, the peripheral block wins over EEPROM, EEPROM wins over internal RAM, and external RAM loses to all of them.
- R8: Exactly one bit of region_sel is set for every address. An address in no block drives region_sel = 4'b1000 (external RAM).
- R9: With WIDE_IO = 1, the peripheral block spans 1024 bytes from the same base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the window straps are captured while it is high |
| win_lo | input | 16 | Strap: first logical address inside the bank window |
| win_hi | input | 16 | Strap: first logical address past the bank window |
| win_shift | input | 4 | Strap: left shift applied to the page value |
| virt_base | input | 24 | Strap: physical offset added to translated addresses |
| cpu_addr | input | 16 | Logical address from the core |
| page_reg | input | 8 | Current page register |
| init_reg | input | 8 | Relocation register; [3:0] sets the peripheral base, [7:4] sets the internal RAM base |
| phys_addr | output | 24 | Physical address |
| region_sel | output | 4 | One-hot select: bit0 peripheral, bit1 EEPROM, bit2 internal RAM, bit3 external RAM |

## Verification
The assertions check several properties on every cycle after reset. They check that exactly one region is selected, that addresses outside the captured window pass through untouched, that an address in the peripheral block always selects it, and that external RAM is never chosen for an address inside the relocated RAM block. They also check that with address, page and init held steady, the physical address stays steady even while the straps change. Other behaviour is only shown by the bench scenarios against its model. That covers the arithmetic of the translation and its 24-bit wrap, the exact window edges, the EEPROM-over-RAM ordering, the effect of a second reset with new straps, and the wide peripheral span.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int LA_W    = 16;
    localparam int PA_W    = 24;
    localparam int PG_W    = 8;
    localparam int SH_W    = 4;
    localparam int INIT_W  = 8;
    localparam int STEP_AW = 12;
    localparam int NRGN    = 4;

    typedef enum logic [NRGN-1:0] {
        RGN_IO   = 4'b0001,
        RGN_EE   = 4'b0010,
        RGN_NV   = 4'b0100,
        RGN_XRAM = 4'b1000
    } region_t;

    typedef struct packed {
        logic [LA_W-1:0] lo;
        logic [LA_W-1:0] hi;
        logic [SH_W-1:0] shift;
        logic [PA_W-1:0] virt;
    } win_cfg_t;

    function automatic logic blk_hit(input logic [LA_W-1:0] a,
                                     input logic [LA_W-1:0] base,
                                     input int unsigned     span_aw);
        logic [LA_W-1:0] mask;
        mask = ~((LA_W'(1) << span_aw) - LA_W'(1));
        return (a & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/win_cfg_reg.sv
module win_cfg_reg
    import addr_map_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_cfg_t cfg_in,
    output win_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
    import addr_map_pkg::*;
(
    input  win_cfg_t        cfg,
    input  logic [LA_W-1:0] la,
    input  logic [PG_W-1:0] page,
    output logic [PA_W-1:0] pa
);
    logic            in_win;
    logic [LA_W-1:0] offset;
    logic [PA_W-1:0] paged;

    always_comb begin
        in_win = (la >= cfg.lo) && (la < cfg.hi);
        offset = la - cfg.lo;
        paged  = PA_W'(page) << cfg.shift;
        pa     = in_win ? (PA_W'(offset) + paged + cfg.virt) : PA_W'(la);
    end
endmodule

// File: rtl/region_decode.sv
module region_decode
    import addr_map_pkg::*;
#(
    parameter bit              WIDE_IO = 1'b0,
    parameter logic [LA_W-1:0] EE_BASE = 16'hF000,
    parameter int              EE_AW   = 9,
    parameter int              RAM_AW  = 8
) (
    input  logic [LA_W-1:0]   la,
    input  logic [INIT_W-1:0] init,
    output region_t           sel
);
    localparam int IO_AW = WIDE_IO ? 10 : 6;
    localparam int NHIT  = NRGN - 1;

    logic [LA_W-1:0] base [NHIT];
    logic [NHIT-1:0] hit;

    assign base[0] = LA_W'(init[3:0]) << STEP_AW;
    assign base[1] = EE_BASE;
    assign base[2] = LA_W'(init[7:4]) << STEP_AW;

    genvar gi;
    generate
        for (gi = 0; gi < NHIT; gi++) begin : g_hit
            localparam int AW = (gi == 0) ? IO_AW : ((gi == 1) ? EE_AW : RAM_AW);
            assign hit[gi] = blk_hit(la, base[gi], AW);
        end
    endgenerate

    always_comb begin
        sel = RGN_XRAM;
        for (int i = NHIT - 1; i >= 0; i--) begin
            if (hit[i]) sel = region_t'(NRGN'(1) << i);
        end
    end
endmodule

// File: rtl/banked_addr_map.sv
module banked_addr_map
    import addr_map_pkg::*;
#(
    parameter bit          WIDE_IO = 1'b0,
    parameter logic [15:0] EE_BASE = 16'hF000,
    parameter int          EE_AW   = 9,
    parameter int          RAM_AW  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] win_lo,
    input  logic [15:0] win_hi,
    input  logic [3:0]  win_shift,
    input  logic [23:0] virt_base,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  page_reg,
    input  logic [7:0]  init_reg,
    output logic [23:0] phys_addr,
    output logic [3:0]  region_sel
);
    win_cfg_t cfg_in;
    win_cfg_t cfg_q;
    region_t  sel;

    assign cfg_in = '{lo: win_lo, hi: win_hi, shift: win_shift, virt: virt_base};

    win_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    bank_xlate u_xlate (
        .cfg  (cfg_q),
        .la   (cpu_addr),
        .page (page_reg),
        .pa   (phys_addr)
    );

    region_decode #(
        .WIDE_IO (WIDE_IO),
        .EE_BASE (EE_BASE),
        .EE_AW   (EE_AW),
        .RAM_AW  (RAM_AW)
    ) u_dec (
        .la   (cpu_addr),
        .init (init_reg),
        .sel  (sel)
    );

    assign region_sel = sel;
endmodule

// File: rtl/banked_addr_map_chk.sv
module banked_addr_map_chk #(
    parameter bit WIDE_IO = 1'b0,
    parameter int RAM_AW  = 8
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] win_lo,
    input logic [15:0] win_hi,
    input logic [3:0]  win_shift,
    input logic [23:0] virt_base,
    input logic [15:0] cpu_addr,
    input logic [7:0]  page_reg,
    input logic [7:0]  init_reg,
    input logic [15:0] cap_lo,
    input logic [15:0] cap_hi,
    input logic [23:0] phys_addr,
    input logic [3:0]  region_sel
);
    localparam int IO_AW = WIDE_IO ? 10 : 6;

    logic in_io, in_ram;
    assign in_io  = (cpu_addr[15:12] == init_reg[3:0]) && (cpu_addr[11:IO_AW] == '0);
    assign in_ram = (cpu_addr[15:12] == init_reg[7:4]) && (cpu_addr[11:RAM_AW] == '0);

    a_r8_one_region: assert property (@(posedge clk) disable iff (rst)
        $countones(region_sel) == 1);

    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        !((cpu_addr >= cap_lo) && (cpu_addr < cap_hi)) |-> (phys_addr == {8'h00, cpu_addr}));

    a_r4_io_claims: assert property (@(posedge clk) disable iff (rst)
        in_io |-> (region_sel == 4'b0001));

    a_r7_xram_lowest: assert property (@(posedge clk) disable iff (rst)
        region_sel[3] |-> !in_ram);

    a_r3_straps_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(cpu_addr) && $stable(page_reg) && $stable(init_reg))
        |-> $stable(phys_addr));

endmodule

bind banked_addr_map banked_addr_map_chk #(.WIDE_IO(WIDE_IO), .RAM_AW(RAM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .win_lo     (win_lo),
    .win_hi     (win_hi),
    .win_shift  (win_shift),
    .virt_base  (virt_base),
    .cpu_addr   (cpu_addr),
    .page_reg   (page_reg),
    .init_reg   (init_reg),
    .cap_lo     (cfg_q.lo),
    .cap_hi     (cfg_q.hi),
    .phys_addr  (phys_addr),
    .region_sel (region_sel)
);

// File: tb/sim_banked_addr_map.sv
`timescale 1ns/1ps
module sim_banked_addr_map;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] win_lo = 16'h4000, win_hi = 16'h8000;
    logic [3:0]  win_shift = 4'd14;
    logic [23:0] virt_base = 24'h100000;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  page_reg = 8'h00, init_reg = 8'h00;
    logic [23:0] phys0, phys1;
    logic [3:0]  sel0, sel1;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // straps as the bench captured them during reset
    int m_lo = 'h4000, m_hi = 'h8000, m_sh = 14, m_virt = 'h100000;

    always #4 clk = ~clk;

    banked_addr_map u0 (.clk(clk), .rst(rst), .win_lo(win_lo), .win_hi(win_hi),
        .win_shift(win_shift), .virt_base(virt_base), .cpu_addr(cpu_addr),
        .page_reg(page_reg), .init_reg(init_reg), .phys_addr(phys0), .region_sel(sel0));

    banked_addr_map #(.WIDE_IO(1'b1)) u1 (.clk(clk), .rst(rst), .win_lo(win_lo), .win_hi(win_hi),
        .win_shift(win_shift), .virt_base(virt_base), .cpu_addr(cpu_addr),
        .page_reg(page_reg), .init_reg(init_reg), .phys_addr(phys1), .region_sel(sel1));

    function automatic int exp_phys(int a, int pg);
        if (a >= m_lo && a < m_hi)
            return ((a - m_lo) + (pg * (1 << m_sh)) + m_virt) % (1 << 24);
        return a;
    endfunction

    function automatic int exp_sel(int a, int init, bit wide);
        int io_b, nv_b, io_n;
        io_b = (init % 16) * 4096;
        nv_b = (init / 16) * 4096;
        io_n = wide ? 1024 : 64;
        if (a >= io_b && a < io_b + io_n) return 1;
        if (a >= 'hF000 && a < 'hF200)   return 2;
        if (a >= nv_b && a < nv_b + 256) return 4;
        return 8;
    endfunction

    task automatic compare(string tag);
        int ep, es0, es1;
        ep  = exp_phys(cpu_addr, page_reg);
        es0 = exp_sel(cpu_addr, init_reg, 1'b0);
        es1 = exp_sel(cpu_addr, init_reg, 1'b1);
        n_cmp++;
        if (phys0 !== 24'(ep) || sel0 !== 4'(es0) || phys1 !== 24'(ep) || sel1 !== 4'(es1)) begin
            n_bad++;
            $display("FAIL %s addr=%h page=%h init=%h: u0 %h/%b u1 %h/%b expected %h/%b wide-sel %b",
                     tag, cpu_addr, page_reg, init_reg, phys0, sel0, phys1, sel1,
                     24'(ep), 4'(es0), 4'(es1));
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [7:0] pg,
                        input logic [7:0] ini, input string tag);
        @(posedge clk); #1;
        cpu_addr = a; page_reg = pg; init_reg = ini;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(int lo, int hi, int sh, int vb);
        @(posedge clk); #1;
        rst = 1'b1;
        win_lo = 16'(lo); win_hi = 16'(hi); win_shift = 4'(sh); virt_base = 24'(vb);
        m_lo = lo; m_hi = hi; m_sh = sh; m_virt = vb;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        // reset state: straps captured at first edge, addr 0 lies in the peripheral block
        @(negedge clk);
        compare("R4 reset-state");
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        // R1 window translation
        step(16'h4000, 8'h03, 8'h00, "R1 window-start");
        step(16'h7FFF, 8'hFF, 8'h00, "R1 window-last");
        step(16'h5A5A, 8'h10, 8'h00, "R1 window-mid");
        // R2 edges outside the window
        step(16'h8000, 8'h03, 8'h00, "R2 at-hi");
        step(16'h3FFF, 8'h03, 8'h00, "R2 below-lo");
        step(16'hFFFF, 8'h77, 8'h00, "R2 top");
        // R4 / R9 peripheral block
        step(16'h103F, 8'h00, 8'h21, "R4 io-last");
        step(16'h1040, 8'h00, 8'h21, "R9 past-narrow-io");
        step(16'h13FF, 8'h00, 8'h21, "R9 wide-io-last");
        step(16'h1400, 8'h00, 8'h21, "R9 past-wide-io");
        // R5 internal RAM
        step(16'h2080, 8'h00, 8'h21, "R5 ram-mid");
        step(16'h20FF, 8'h00, 8'h21, "R5 ram-last");
        step(16'h2100, 8'h00, 8'h21, "R8 past-ram");
        // R6 EEPROM and R7 priority
        step(16'hF1FF, 8'h00, 8'h00, "R6 ee-last");
        step(16'hF200, 8'h00, 8'h00, "R8 past-ee");
        step(16'hF010, 8'h00, 8'hFF, "R7 io-over-ee-ram");
        step(16'hF050, 8'h00, 8'hFF, "R7 ee-over-ram");
        step(16'hF050, 8'h00, 8'hF0, "R7 ee-over-ram-2");
        step(16'h0050, 8'h00, 8'h00, "R7 io-over-ram");
        step(16'h9000, 8'h00, 8'h21, "R8 unclaimed");

        // R3 straps change while running: no effect
        @(posedge clk); #1;
        win_lo = 16'h0000; win_hi = 16'hFFFF; win_shift = 4'd0; virt_base = 24'hABCDEF;
        step(16'h5000, 8'h02, 8'h21, "R3 straps-ignored");
        step(16'h0100, 8'h02, 8'h21, "R3 straps-ignored-outside");

        // R3 new straps taken by a second reset; R1 24-bit wrap
        do_reset('h0000, 'h1000, 12, 'hFF0000);
        step(16'h0FFF, 8'h0F, 8'h50, "R1 top-of-space");
        step(16'h0FFF, 8'h10, 8'h50, "R1 wrap");
        step(16'h1000, 8'h10, 8'h50, "R2 at-hi-2");
        step(16'h0000, 8'h00, 8'h50, "R3 new-straps");

        // mixed patterns
        for (int i = 0; i < 300; i++)
            step(16'($urandom), 8'($urandom), 8'($urandom), "R8 random");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule